// File: doc/BRIEF.md
# Hot-Plug Slot Interrupt Generator

This block produces the software notification for hot-plug events on one slot of a PCI Express root or downstream port. It holds a slot event status register and a slot interrupt control register. Each status bit is set by a one-cycle pulse from the slot hardware and cleared by writing a one to it. The control register has one enable per event and a master hot-plug interrupt enable.

A single stored notification condition is recomputed in every cycle, from the values the registers will hold after that cycle's event, write and slot reset. When MSI is off, the legacy INTx line follows this condition as a level. When MSI is on, a one-cycle MSI request is raised only when the condition goes from false to true. Masking is not tracked separately. An event latched while it was disabled therefore raises a notification on the cycle that software enables it.

Bit positions are shared by status and control: attention button pressed at 0, power fault at 1, latch sensor changed at 2, presence detect changed at 3, command completed at 4, and link state changed at 8. The master enable is control bit 5.

Top module: `hpn_slot_irq`

## Requirements
- R1: After hardware reset, both registers read zero and `intx_o` and `msi_req_o` are low.
- R2: A write to control (`cfg_sel_i`=0) stores bits 0 to 5 and 8. Every other control bit reads zero.
- R3: An event pulse on a supported position (0 to 4 or 8) sets that status bit at the next clock edge. Pulses on other positions have no effect, and those status bits read zero.
- R4: A write to status (`cfg_sel_i`=1) clears each supported bit written as one and leaves bits written as zero unchanged. An event on a bit in the same cycle as its clear leaves the bit set.
- R5: The condition is true when control bit 5 is set and some supported position has both its status bit and its control bit set. With `msi_en_i` low, `intx_o` equals the condition from the same edge that updates the registers.
- R6: With `msi_en_i` low, `intx_o` falls at the edge where the condition becomes false, whether by a status clear or by an enable being turned off.
- R7: With `msi_en_i` high, `msi_req_o` is high for exactly one cycle after the edge where the condition goes from false to true. A true-to-false change raises nothing, and `intx_o` stays low.
- R8: An event on a status bit that is already set changes nothing and raises no new MSI request.
- R9: An event latched while its enable or the master enable was off raises a notification at the edge where the enable is written on.
- R10: A slot reset pulse (`slot_rst_i`) clears status bits 0, 3 and 4. It keeps bits 1, 2 and 8 and the whole control register, and the condition is recomputed in the same cycle.
- R11: After the condition has fallen, a new rise raises a new MSI request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | 0 selects control, 1 selects status |
| cfg_wdata_i | input | 16 | Write data |
| evt_i | input | 16 | One-cycle event pulses at the status bit positions |
| slot_rst_i | input | 1 | Slot reset pulse |
| msi_en_i | input | 1 | MSI enable level |
| ctrl_o | output | 16 | Control register value |
| status_o | output | 16 | Status register value |
| intx_o | output | 1 | Level-sensitive legacy interrupt |
| msi_req_o | output | 1 | One-cycle MSI request |

## Verification
The bench targets the edge-versus-level split. A design that derived MSI from the level would raise a request every cycle, or on the falling edge. A design that ignored masked history would stay silent when an enable is written on over a latched event. The same-cycle race between an event and a clear of the same bit is also checked: the wrong priority drops an event. Repeated events on a set bit are checked because a re-trigger would show a second request. The slot reset must spare bits 1, 2 and 8; a design that cleared them would lower INTx when it should stay high.

// File: rtl/hpn_pkg.sv
package hpn_pkg;
    localparam int unsigned REG_W = 16;

    typedef logic [REG_W-1:0] reg_word_t;

    typedef struct packed {
        logic cond;
        logic intx;
        logic msi;
    } notify_state_t;
endpackage

// File: rtl/hpn_ctrl_reg.sv
module hpn_ctrl_reg
    import hpn_pkg::*;
#(
    parameter reg_word_t WR_MASK = 16'h013F
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      wr_i,
    input  reg_word_t wdata_i,
    output reg_word_t ctrl_d_o,
    output reg_word_t ctrl_q_o
);
    reg_word_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_i) begin
            ctrl_d = wdata_i & WR_MASK;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl_d_o = ctrl_d;
    assign ctrl_q_o = ctrl_q;
endmodule

// File: rtl/hpn_status_reg.sv
module hpn_status_reg
    import hpn_pkg::*;
#(
    parameter reg_word_t EVT_MASK  = 16'h011F,
    parameter reg_word_t SRST_MASK = 16'h0019
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      clr_wr_i,
    input  reg_word_t clr_data_i,
    input  reg_word_t evt_i,
    input  logic      slot_rst_i,
    output reg_word_t stat_d_o,
    output reg_word_t stat_q_o
);
    reg_word_t stat_d, stat_q;
    reg_word_t bit_next;

    // One cell per position; unsupported positions are tied to zero.
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (EVT_MASK[b]) begin : g_live
            logic drop;
            always_comb begin
                drop = (clr_wr_i && clr_data_i[b]) || (slot_rst_i && SRST_MASK[b]);
                // A pulse in the same cycle overrides any clear.
                bit_next[b] = evt_i[b] || (stat_q[b] && !drop);
            end
        end else begin : g_tied
            assign bit_next[b] = 1'b0;
        end
    end

    always_comb begin
        stat_d = bit_next;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat_d_o = stat_d;
    assign stat_q_o = stat_q;
endmodule

// File: rtl/hpn_notify.sv
module hpn_notify
    import hpn_pkg::*;
#(
    parameter reg_word_t   EVT_MASK   = 16'h011F,
    parameter int unsigned MASTER_BIT = 5
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  reg_word_t ctrl_next_i,
    input  reg_word_t stat_next_i,
    input  logic      msi_en_i,
    output logic      intx_o,
    output logic      msi_req_o
);
    notify_state_t st_d, st_q;
    logic          cond_next;

    always_comb begin
        cond_next = ctrl_next_i[MASTER_BIT]
                 && (|(ctrl_next_i & stat_next_i & EVT_MASK));
        st_d      = st_q;
        st_d.cond = cond_next;
        // The line follows the stored level only while MSI is off.
        st_d.intx = cond_next && !msi_en_i;
        // A request goes out only on a false-to-true change.
        st_d.msi  = msi_en_i && cond_next && !st_q.cond;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign intx_o    = st_q.intx;
    assign msi_req_o = st_q.msi;
endmodule

// File: rtl/hpn_slot_irq.sv
module hpn_slot_irq
    import hpn_pkg::*;
#(
    parameter reg_word_t   EVT_MASK   = 16'h011F,
    parameter int unsigned MASTER_BIT = 5,
    parameter reg_word_t   SRST_MASK  = 16'h0019,
    localparam reg_word_t  CTRL_MASK  = EVT_MASK | (reg_word_t'(1) << MASTER_BIT)
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        cfg_wr_i,
    input  logic        cfg_sel_i,
    input  logic [15:0] cfg_wdata_i,
    input  logic [15:0] evt_i,
    input  logic        slot_rst_i,
    input  logic        msi_en_i,
    output logic [15:0] ctrl_o,
    output logic [15:0] status_o,
    output logic        intx_o,
    output logic        msi_req_o
);
    reg_word_t ctrl_next, ctrl_cur, stat_next, stat_cur;
    logic      wr_ctrl, wr_stat;

    always_comb begin
        wr_ctrl = cfg_wr_i && !cfg_sel_i;
        wr_stat = cfg_wr_i &&  cfg_sel_i;
    end

    hpn_ctrl_reg #(.WR_MASK(CTRL_MASK)) u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (wr_ctrl),
        .wdata_i  (cfg_wdata_i),
        .ctrl_d_o (ctrl_next),
        .ctrl_q_o (ctrl_cur)
    );

    hpn_status_reg #(.EVT_MASK(EVT_MASK), .SRST_MASK(SRST_MASK)) u_stat (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_wr_i   (wr_stat),
        .clr_data_i (cfg_wdata_i),
        .evt_i      (evt_i),
        .slot_rst_i (slot_rst_i),
        .stat_d_o   (stat_next),
        .stat_q_o   (stat_cur)
    );

    hpn_notify #(.EVT_MASK(EVT_MASK), .MASTER_BIT(MASTER_BIT)) u_ntf (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ctrl_next_i (ctrl_next),
        .stat_next_i (stat_next),
        .msi_en_i    (msi_en_i),
        .intx_o      (intx_o),
        .msi_req_o   (msi_req_o)
    );

    assign ctrl_o   = ctrl_cur;
    assign status_o = stat_cur;
endmodule

// File: rtl/hpn_slot_irq_chk.sv
module hpn_slot_irq_chk #(
    parameter logic [15:0] EVT_MASK   = 16'h011F,
    parameter int unsigned MASTER_BIT = 5
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [15:0] evt_i,
    input logic        msi_en_i,
    input logic [15:0] ctrl_o,
    input logic [15:0] status_o,
    input logic        intx_o,
    input logic        msi_req_o
);
    assert_unsup_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o & ~EVT_MASK) == 16'h0000);

    assert_evt_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(evt_i & EVT_MASK)) |=>
        ((status_o & $past(evt_i & EVT_MASK)) == $past(evt_i & EVT_MASK)));

    assert_intx_cond_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        intx_o |-> (ctrl_o[MASTER_BIT] && (|(ctrl_o & status_o & EVT_MASK))));

    assert_msi_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        msi_req_o |=> !msi_req_o);

    assert_msi_quiet_intx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        msi_en_i |=> !intx_o);

    assert_msi_cond_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        msi_req_o |-> (ctrl_o[MASTER_BIT] && (|(ctrl_o & status_o & EVT_MASK))));
endmodule

bind hpn_slot_irq hpn_slot_irq_chk #(.EVT_MASK(EVT_MASK), .MASTER_BIT(MASTER_BIT)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .msi_en_i  (msi_en_i),
    .ctrl_o    (ctrl_o),
    .status_o  (status_o),
    .intx_o    (intx_o),
    .msi_req_o (msi_req_o)
);

// File: tb/sim_hpn_slot_irq.sv
`timescale 1ns/1ps
module sim_hpn_slot_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0, evt = '0;
    logic        slot_rst = 1'b0, msi_en = 1'b0;
    logic [15:0] ctrl, status;
    logic        intx, msi_req;
    int          n_checks = 0, n_errors = 0;

    always #10 clk = ~clk;

    hpn_slot_irq u0 (
        .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel),
        .cfg_wdata_i(cfg_wdata), .evt_i(evt), .slot_rst_i(slot_rst),
        .msi_en_i(msi_en), .ctrl_o(ctrl), .status_o(status),
        .intx_o(intx), .msi_req_o(msi_req)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Inputs change at the falling edge; results are read at the next one.
    task automatic step();
        @(negedge clk);
        cfg_wr = 1'b0; evt = '0; slot_rst = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [15:0] v);
        cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = v; step();
    endtask

    task automatic wr_stat(input logic [15:0] v);
        cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_wdata = v; step();
    endtask

    task automatic fire(input logic [15:0] v);
        evt = v; step();
    endtask

    task automatic t_reset();
        check("R1 ctrl", ctrl, 16'h0000);
        check("R1 status", status, 16'h0000);
        check("R1 intx", {15'b0, intx}, 16'h0000);
        check("R1 msi", {15'b0, msi_req}, 16'h0000);
    endtask

    task automatic t_ctrl();
        wr_ctrl(16'hFFFF);
        check("R2 writable bits", ctrl, 16'h013F);
        wr_ctrl(16'h0000);
        check("R2 clear", ctrl, 16'h0000);
    endtask

    task automatic t_events_w1c();
        fire(16'hFFFF);
        check("R3 supported set", status, 16'h011F);
        check("R3 no intx while disabled", {15'b0, intx}, 16'h0000);
        wr_stat(16'h0003);
        check("R4 w1c", status, 16'h011C);
        wr_stat(16'h0000);
        check("R4 zero write", status, 16'h011C);
        evt = 16'h0001; cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_wdata = 16'h0005; step();
        check("R4 event beats clear", status, 16'h0119);
        wr_stat(16'hFFFF);
        check("R4 clear all", status, 16'h0000);
    endtask

    task automatic t_intx();
        msi_en = 1'b0;
        wr_ctrl(16'h0028);
        fire(16'h0001);
        check("R5 other bit no intx", {15'b0, intx}, 16'h0000);
        fire(16'h0008);
        check("R5 intx rises", {15'b0, intx}, 16'h0001);
        check("R5 no msi", {15'b0, msi_req}, 16'h0000);
        wr_stat(16'h0008);
        check("R6 intx falls on clear", {15'b0, intx}, 16'h0000);
        fire(16'h0008);
        check("R5 intx again", {15'b0, intx}, 16'h0001);
        wr_ctrl(16'h0008);
        check("R6 intx falls on master off", {15'b0, intx}, 16'h0000);
        wr_stat(16'hFFFF);
        wr_ctrl(16'h0000);
    endtask

    task automatic t_msi();
        msi_en = 1'b1;
        wr_ctrl(16'h0030);
        fire(16'h0010);
        check("R7 msi pulse", {15'b0, msi_req}, 16'h0001);
        check("R7 intx low", {15'b0, intx}, 16'h0000);
        step();
        check("R7 pulse one cycle", {15'b0, msi_req}, 16'h0000);
        fire(16'h0010);
        check("R8 repeat event no msi", {15'b0, msi_req}, 16'h0000);
        check("R8 status unchanged", status, 16'h0010);
        wr_stat(16'h0010);
        check("R7 fall no msi", {15'b0, msi_req}, 16'h0000);
        fire(16'h0010);
        check("R11 rearmed msi", {15'b0, msi_req}, 16'h0001);
        wr_stat(16'hFFFF);
        wr_ctrl(16'h0000);
    endtask

    task automatic t_masked();
        msi_en = 1'b1;
        wr_ctrl(16'h0020);
        fire(16'h0100);
        check("R9 masked no msi", {15'b0, msi_req}, 16'h0000);
        check("R9 latched", status, 16'h0100);
        wr_ctrl(16'h0120);
        check("R9 msi on enable", {15'b0, msi_req}, 16'h0001);
        wr_stat(16'hFFFF);
        wr_ctrl(16'h0000);
        msi_en = 1'b0;
        fire(16'h0002);
        wr_ctrl(16'h0022);
        check("R9 intx on enable", {15'b0, intx}, 16'h0001);
        wr_stat(16'hFFFF);
        wr_ctrl(16'h0000);
    endtask

    task automatic t_slot_reset();
        msi_en = 1'b0;
        wr_ctrl(16'h013F);
        fire(16'h0019);
        check("R10 intx before", {15'b0, intx}, 16'h0001);
        slot_rst = 1'b1; step();
        check("R10 bits cleared", status, 16'h0000);
        check("R10 intx drops", {15'b0, intx}, 16'h0000);
        fire(16'h0107);
        slot_rst = 1'b1; step();
        check("R10 kept bits", status, 16'h0106);
        check("R10 ctrl kept", ctrl, 16'h013F);
        check("R10 intx held", {15'b0, intx}, 16'h0001);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_ctrl();
        t_events_w1c();
        t_intx();
        t_msi();
        t_masked();
        t_slot_reset();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule